// File: doc/BRIEF.md
# Shared-Pool Four-Port Packet Queue

This block is a byte switch for four ports that keeps all in-flight data in a single on-chip memory. The memory is cut into fixed-size chunks. Every egress destination owns a linked list of chunks, and a recycling queue holds the indices of the chunks that nobody owns. A destination takes a fresh chunk only when the last byte of its current tail chunk has been filled. It gives a chunk back as soon as the final byte of its head chunk has been read out.

Each ingress port hands over one byte at a time with a valid/ready handshake. The byte carries a 2-bit destination index and lands in a one-byte holding register. A rotating pointer drains one holding register per clock into the pool. When the pool has no chunk to give, the byte is discarded and counted. On the egress side, a second rotating pointer fetches one byte per clock from the head of a destination list into that destination's output register. The output register presents the byte with its source port index under a valid/ready handshake.

Top module: `pool_switch`

## Requirements
- R1: A synchronous, active-high reset empties every destination list, makes `in_ready` all ones and `out_valid` all zeros, clears `drop_count`, and returns every chunk to the recycling queue.
- R2: When `in_valid[p]` and `in_ready[p]` are both high at a clock edge, the byte is captured and `in_ready[p]` is low from the next cycle until the holding register is emptied.
- R3: Holding registers are emptied in the rotating order 0, 1, 2, 3, with one port visited per clock starting at port 0 after reset. `in_ready[p]` returns high in the cycle after its port is visited.
- R4: A byte sent with `in_dest[p] = d` comes out on egress port `d`, and `out_src[d]` equals the ingress port index `p`.
- R5: For each destination, bytes leave in the order in which their holding registers were emptied into the pool.
- R6: While `out_valid[d]` is high and `out_ready[d]` is low, the presented byte and source stay unchanged. After a transfer, `out_valid[d]` is low in the next cycle, so no byte is delivered twice.
- R7: With the default 64 chunks of 16 bytes, a single destination can hold 1024 bytes when nothing is drained. A chunk is taken from the recycling queue only when a byte needs a slot and the destination's tail chunk is already full, or the destination has no tail chunk.
- R8: A byte that needs a new chunk while the recycling queue is empty is discarded, its holding register is still emptied, and `drop_count` rises by one.
- R9: A chunk whose last byte has been read returns to the recycling queue. After a full drain, the pool again holds 1024 bytes for one destination.
- R10: Releasing a chunk and allocating a chunk in the same clock, and writing and reading the same destination in the same clock, lose and reorder no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Per-port ingress byte valid |
| in_ready | output | 4 | Per-port holding register empty |
| in_data | input | 32 | Per-port ingress byte, port p in bits 8p+7..8p |
| in_dest | input | 8 | Per-port destination index, port p in bits 2p+1..2p |
| out_valid | output | 4 | Per-destination egress byte valid |
| out_ready | input | 4 | Per-destination egress accept |
| out_data | output | 32 | Per-destination egress byte, destination d in bits 8d+7..8d |
| out_src | output | 8 | Per-destination source port index, destination d in bits 2d+1..2d |
| drop_count | output | 16 | Saturating count of discarded bytes |

## Verification
Two functions can fall in the same cycle: a chunk is released when a head byte is read, and a chunk is allocated when a tail fills. A destination can also be written and read in one clock while its list holds only a few bytes. The bench provokes both by filling one destination past a chunk boundary with its egress stalled, then releasing egress while another port keeps writing to that same destination. Both conditions are judged by comparing every delivered byte and source against a behavioural per-destination queue model, by checking that no drop occurs, and by a later fill after a full drain that must again accept exactly 1024 bytes.

// File: rtl/pool_pkg.sv
package pool_pkg;
    localparam int PORTS = 4;
    localparam int PW    = 2;
    localparam int BW    = 8;

    typedef logic [PW-1:0] port_t;
    typedef logic [BW-1:0] byte_t;

    // One byte as stored in the pool: payload with its ingress port.
    typedef struct packed {
        port_t src;
        byte_t data;
    } cell_t;

    // Ingress holding register.
    typedef struct packed {
        logic  busy;
        port_t dest;
        byte_t data;
    } hold_t;

    function automatic port_t next_port(input port_t p);
        return p + port_t'(1);
    endfunction
endpackage

// File: rtl/pool_ingress.sv
module pool_ingress
    import pool_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [PORTS-1:0]          in_valid,
    output logic [PORTS-1:0]          in_ready,
    input  logic [PORTS-1:0][BW-1:0]  in_data,
    input  logic [PORTS-1:0][PW-1:0]  in_dest,
    output logic                      svc_go,
    output port_t                     svc_src,
    output port_t                     svc_dest,
    output byte_t                     svc_data
);
    hold_t hold [PORTS];
    port_t rr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PORTS; i++) hold[i] <= '0;
            rr <= '0;
        end else begin
            for (int i = 0; i < PORTS; i++) begin
                if (in_valid[i] && !hold[i].busy)
                    hold[i] <= '{busy: 1'b1, dest: in_dest[i], data: in_data[i]};
                else if (port_t'(i) == rr && hold[i].busy)
                    hold[i].busy <= 1'b0;
            end
            rr <= next_port(rr);
        end
    end

    always_comb begin
        for (int i = 0; i < PORTS; i++) in_ready[i] = !hold[i].busy;
        svc_go   = hold[rr].busy;
        svc_src  = rr;
        svc_dest = hold[rr].dest;
        svc_data = hold[rr].data;
    end

    for (genvar g = 0; g < PORTS; g++) begin : g_chk
        assert_capture_blocks_R2: assert property (@(posedge clk) disable iff (rst)
            (in_valid[g] && in_ready[g]) |=> !in_ready[g]);
        assert_visit_empties_R3: assert property (@(posedge clk) disable iff (rst)
            (!in_ready[g] && rr == port_t'(g)) |=> in_ready[g]);
    end
endmodule

// File: rtl/pool_freelist.sv
module pool_freelist #(
    parameter int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    output logic [IW-1:0] pop_id,
    output logic          avail,
    input  logic          push,
    input  logic [IW-1:0] push_id
);
    logic [IW-1:0] ent [N];
    logic [IW-1:0] rd_ptr, wr_ptr;
    logic [IW:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= IW'(i);
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= (IW+1)'(N);
        end else begin
            if (push) begin
                ent[wr_ptr] <= push_id;
                wr_ptr      <= wr_ptr + IW'(1);
            end
            if (pop) rd_ptr <= rd_ptr + IW'(1);
            cnt <= cnt + (IW+1)'(push) - (IW+1)'(pop);
        end
    end

    assign pop_id = ent[rd_ptr];
    assign avail  = (cnt != '0);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt != (IW+1)'(N)));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0));
endmodule

// File: rtl/pool_ram.sv
module pool_ram
    import pool_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cell_t         wdata,
    input  logic [AW-1:0] raddr,
    output cell_t         rdata
);
    cell_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pool_egress.sv
module pool_egress
    import pool_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  port_t                     load_dest,
    input  cell_t                     load_cell,
    input  logic [PORTS-1:0]          out_ready,
    output logic [PORTS-1:0]          out_valid,
    output logic [PORTS-1:0][BW-1:0]  out_data,
    output logic [PORTS-1:0][PW-1:0]  out_src
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= '0;
        end else begin
            for (int i = 0; i < PORTS; i++) begin
                if (load && load_dest == port_t'(i))
                    out_valid[i] <= 1'b1;
                else if (out_ready[i])
                    out_valid[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PORTS; i++) begin
            if (load && load_dest == port_t'(i)) begin
                out_data[i] <= load_cell.data;
                out_src[i]  <= load_cell.src;
            end
        end
    end

    assert_load_into_empty_R6: assert property (@(posedge clk) disable iff (rst)
        load |-> !out_valid[load_dest]);

    for (genvar g = 0; g < PORTS; g++) begin : g_chk
        assert_no_duplicate_R6: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && out_ready[g]) |=> !out_valid[g]);
        assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && !out_ready[g]) |=> (out_valid[g] && $stable(out_data[g]) && $stable(out_src[g])));
    end
endmodule

// File: rtl/pool_switch.sv
module pool_switch
    import pool_pkg::*;
#(
    parameter int CHUNK_BYTES = 16,
    parameter int NUM_CHUNKS  = 64,
    parameter int DROP_W      = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [PORTS-1:0]          in_valid,
    output logic [PORTS-1:0]          in_ready,
    input  logic [PORTS-1:0][BW-1:0]  in_data,
    input  logic [PORTS-1:0][PW-1:0]  in_dest,
    output logic [PORTS-1:0]          out_valid,
    input  logic [PORTS-1:0]          out_ready,
    output logic [PORTS-1:0][BW-1:0]  out_data,
    output logic [PORTS-1:0][PW-1:0]  out_src,
    output logic [DROP_W-1:0]         drop_count
);
    localparam int OFF_W = $clog2(CHUNK_BYTES);
    localparam int CID_W = $clog2(NUM_CHUNKS);
    localparam int AW    = CID_W + OFF_W;
    localparam int CNT_W = AW + 1;

    // Per-destination linked list of chunks.
    typedef struct packed {
        logic [CID_W-1:0] hc;     // head chunk
        logic [OFF_W-1:0] ho;     // head offset
        logic [CID_W-1:0] tc;     // tail chunk
        logic [OFF_W-1:0] to;     // next free offset in tail chunk
        logic             tneed;  // tail chunk full or absent
        logic [CNT_W-1:0] cnt;    // bytes queued
    } dq_t;

    dq_t              q   [PORTS];
    dq_t              q_n [PORTS];
    logic [CID_W-1:0] nxt [NUM_CHUNKS];

    logic             svc_go;
    port_t            svc_src, svc_dest;
    byte_t            svc_data;
    logic             fl_avail;
    logic [CID_W-1:0] fl_id;
    logic             need, wr_ok, alloc, drop_now, emp;
    logic             rd_go, free_now;
    logic [AW-1:0]    waddr, raddr;
    cell_t            rdata;
    port_t            erd, pend_dest;
    logic             pend;

    pool_ingress u_ing (
        .clk, .rst, .in_valid, .in_ready, .in_data, .in_dest,
        .svc_go, .svc_src, .svc_dest, .svc_data
    );

    pool_freelist #(.N(NUM_CHUNKS)) u_free (
        .clk, .rst, .pop(alloc), .pop_id(fl_id), .avail(fl_avail),
        .push(free_now), .push_id(q[erd].hc)
    );

    pool_ram #(.DEPTH(NUM_CHUNKS * CHUNK_BYTES)) u_ram (
        .clk, .we(wr_ok), .waddr, .wdata('{src: svc_src, data: svc_data}),
        .raddr, .rdata
    );

    pool_egress u_egr (
        .clk, .rst, .load(pend), .load_dest(pend_dest), .load_cell(rdata),
        .out_ready, .out_valid, .out_data, .out_src
    );

    // Write side: decide store, allocate or drop; read side: one destination per clock.
    always_comb begin
        need     = q[svc_dest].tneed;
        wr_ok    = svc_go && (!need || fl_avail);
        alloc    = wr_ok && need;
        drop_now = svc_go && !wr_ok;
        waddr    = need ? {fl_id, OFF_W'(0)} : {q[svc_dest].tc, q[svc_dest].to};
        rd_go    = (q[erd].cnt != '0) && !out_valid[erd];
        raddr    = {q[erd].hc, q[erd].ho};
        free_now = rd_go && (q[erd].ho == {OFF_W{1'b1}});
    end

    // Next list state: pop first, then push, so the push sees the post-pop count.
    always_comb begin
        for (int i = 0; i < PORTS; i++) q_n[i] = q[i];
        emp = 1'b0;
        if (rd_go) begin
            q_n[erd].cnt = q[erd].cnt - CNT_W'(1);
            q_n[erd].ho  = q[erd].ho + OFF_W'(1);
            if (free_now) q_n[erd].hc = nxt[q[erd].hc];
        end
        if (wr_ok) begin
            emp = (q_n[svc_dest].cnt == '0);
            q_n[svc_dest].cnt = q_n[svc_dest].cnt + CNT_W'(1);
            if (need) begin
                q_n[svc_dest].tc    = fl_id;
                q_n[svc_dest].to    = OFF_W'(1);
                q_n[svc_dest].tneed = 1'b0;
                if (emp) begin
                    q_n[svc_dest].hc = fl_id;
                    q_n[svc_dest].ho = '0;
                end
            end else begin
                q_n[svc_dest].to    = q[svc_dest].to + OFF_W'(1);
                q_n[svc_dest].tneed = (q[svc_dest].to == {OFF_W{1'b1}});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PORTS; i++)
                q[i] <= '{hc: '0, ho: '0, tc: '0, to: '0, tneed: 1'b1, cnt: '0};
            erd        <= '0;
            pend       <= 1'b0;
            pend_dest  <= '0;
            drop_count <= '0;
        end else begin
            for (int i = 0; i < PORTS; i++) q[i] <= q_n[i];
            erd       <= next_port(erd);
            pend      <= rd_go;
            pend_dest <= erd;
            if (drop_now && drop_count != {DROP_W{1'b1}})
                drop_count <= drop_count + DROP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc && !emp) nxt[q[svc_dest].tc] <= fl_id;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && in_ready == '1 && drop_count == '0));
    assert_drop_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
        drop_count >= $past(drop_count));
    assert_no_drop_with_room_R7: assert property (@(posedge clk) disable iff (rst)
        (svc_go && !(q[svc_dest].tneed && !fl_avail)) |=> (drop_count == $past(drop_count)));
endmodule

// File: tb/test_pool_switch.sv
module test_pool_switch;
    localparam int CLK_PERIOD = 10;
    localparam int CB = 16;
    localparam int NC = 64;
    localparam int WATCHDOG = 150000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      in_valid = '0;
    logic [3:0]      in_ready;
    logic [3:0][7:0] in_data = '0;
    logic [3:0][1:0] in_dest = '0;
    logic [3:0]      out_valid;
    logic [3:0]      out_ready = '0;
    logic [3:0][7:0] out_data;
    logic [3:0][1:0] out_src;
    logic [15:0]     drop_count;

    pool_switch i_pool_switch (
        .clk, .rst, .in_valid, .in_ready, .in_data, .in_dest,
        .out_valid, .out_ready, .out_data, .out_src, .drop_count
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchecks = 0;
    int nerr    = 0;
    int cyc     = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  mq [4][$];
    bit  mhold [4];
    int  mhdest [4];
    int  mhdata [4];
    int  mrr;
    int  mdrop;
    int  mfree;
    int  mwfill [4];
    int  mrfill [4];
    bit  pstall [4];
    int  pdata [4];
    int  psrc [4];

    function automatic void model_reset();
        for (int i = 0; i < 4; i++) begin
            mq[i].delete();
            mhold[i] = 0; mwfill[i] = CB; mrfill[i] = 0; pstall[i] = 0;
        end
        mrr = 0; mdrop = 0; mfree = NC;
    endfunction

    function automatic void model_store(input int src, input int dst, input int val);
        if (mwfill[dst] == CB) begin
            if (mfree == 0) begin
                if (mdrop < 65535) mdrop++;
                return;
            end
            mfree--;
            mwfill[dst] = 0;
        end
        mwfill[dst]++;
        mq[dst].push_back(src * 256 + val);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            for (int i = 0; i < 4; i++)
                chk(in_ready[i] == !mhold[i], $sformatf("R2/R3 in_ready[%0d]", i), int'(in_ready[i]), int'(!mhold[i]));
            chk(drop_count == 16'(mdrop), "R8 drop_count", int'(drop_count), mdrop);
            for (int d = 0; d < 4; d++) begin
                if (pstall[d])
                    chk(out_valid[d] && int'(out_data[d]) == pdata[d] && int'(out_src[d]) == psrc[d],
                        $sformatf("R6 stall hold dest %0d", d), int'(out_data[d]), pdata[d]);
                if (out_valid[d]) begin
                    if (mq[d].size() == 0) begin
                        chk(1'b0, $sformatf("R6 spurious/duplicate dest %0d", d), 1, 0);
                    end else if (out_ready[d]) begin
                        int e;
                        e = mq[d].pop_front();
                        chk(int'(out_src[d]) == e / 256, $sformatf("R4 src dest %0d", d), int'(out_src[d]), e / 256);
                        chk(int'(out_data[d]) == e % 256, $sformatf("R5 order dest %0d", d), int'(out_data[d]), e % 256);
                        mrfill[d]++;
                        if (mrfill[d] == CB) begin mrfill[d] = 0; mfree++; end
                    end
                end
                pstall[d] = out_valid[d] && !out_ready[d];
                pdata[d]  = int'(out_data[d]);
                psrc[d]   = int'(out_src[d]);
            end
            // ingress step for the coming edge
            begin
                bit snap [4];
                for (int i = 0; i < 4; i++) snap[i] = mhold[i];
                if (mhold[mrr]) begin
                    model_store(mrr, mhdest[mrr], mhdata[mrr]);
                    mhold[mrr] = 0;
                end
                for (int i = 0; i < 4; i++)
                    if (in_valid[i] && !snap[i]) begin
                        mhold[i] = 1; mhdest[i] = int'(in_dest[i]); mhdata[i] = int'(in_data[i]);
                    end
                mrr = (mrr + 1) % 4;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input int p, input int d, input int n, input int base);
        for (int k = 0; k < n; k++) begin
            in_valid[p] = 1'b1;
            in_dest[p]  = 2'(d);
            in_data[p]  = 8'(base + k);
            do @(negedge clk); while (!in_ready[p]);
            @(posedge clk); #1;
        end
        in_valid[p] = 1'b0;
    endtask

    task automatic wait_drain();
        bit done;
        done = 0;
        while (!done) begin
            @(negedge clk); #1;
            done = (mq[0].size() + mq[1].size() + mq[2].size() + mq[3].size() == 0) && out_valid == '0
                   && !mhold[0] && !mhold[1] && !mhold[2] && !mhold[3];
        end
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 4'hf, "R1 in_ready after reset", int'(in_ready), 15);
        chk(out_valid == 4'h0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(drop_count == 16'd0, "R1 drop_count after reset", int'(drop_count), 0);
        @(posedge clk); #1;
    endtask

    initial begin
        do_reset();

        // single bytes, every port to a different destination
        out_ready = 4'hf;
        send(0, 1, 1, 8'h11);
        send(1, 2, 1, 8'h22);
        send(2, 3, 1, 8'h33);
        send(3, 0, 1, 8'h44);
        wait_drain();

        // all ports into destination 0 with intermittent backpressure
        fork
            begin
                fork
                    send(0, 0, 12, 8'h20);
                    send(1, 0, 12, 8'h40);
                    send(2, 0, 12, 8'h60);
                    send(3, 0, 12, 8'h80);
                join
            end
            begin
                for (int k = 0; k < 150; k++) begin
                    out_ready[0] = (k % 3 != 0);
                    @(posedge clk); #1;
                end
                out_ready[0] = 1'b1;
            end
        join
        wait_drain();

        // R10: same-cycle release/allocation and read/write on one destination
        out_ready[1] = 1'b0;
        send(2, 1, 40, 0);
        fork
            begin repeat (2) @(posedge clk); #1; out_ready[1] = 1'b1; end
            send(3, 1, 40, 8'h80);
        join
        wait_drain();
        chk(drop_count == 16'd0, "R10 no drop during concurrent alloc/free", int'(drop_count), 0);

        // R7/R8/R9: capacity, drop and recycling from a clean pool
        do_reset();
        out_ready = 4'h0;
        send(0, 3, NC * CB + 6, 0);
        repeat (8) @(posedge clk); #1;
        chk(drop_count == 16'd6, "R7 capacity 1024 bytes then drops", int'(drop_count), 6);
        out_ready = 4'hf;
        wait_drain();
        out_ready = 4'h0;
        send(1, 2, NC * CB + 1, 8'h5a);
        repeat (8) @(posedge clk); #1;
        chk(drop_count == 16'd7, "R9 all chunks recycled after drain", int'(drop_count), 7);
        out_ready = 4'hf;
        wait_drain();
        chk(out_valid == 4'h0, "R5 all bytes delivered", int'(out_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule